// File: doc/BRIEF.md
# Display List Launch Controller

This block decides where and when a display-list coprocessor begins to fetch instructions. Software reaches it through a small byte-wide register window. The window holds two 16-bit start addresses, a primary one and a secondary one, along with a control register and two launch strobes. The block drives a run flag, a one-cycle program-counter load pulse with the address to load, and the memory bank the list is fetched from. It does not decode or execute instructions. The executor reports the end of a list through a single input.

The control register is guarded by a two-byte key. Until the key is written, control writes are discarded. Once the list is enabled, it starts again from the primary address at every frame start. Clearing the enable stops it at once. A strobe launches a list on the next cycle without waiting for a frame. A list launched from the secondary address can also switch the bank. When that list ends, execution falls back to the primary address in the bank then selected.

Top module: `dl_launch_ctrl`

## Requirements
- R1: After a synchronous reset, dl_run, dl_load and dl_bank are 0. The control key is locked, the enable is 0, and both start addresses are 0.
- R2: While locked, a write to register 0 (control) does not change the enable. The key opens after a control write of 0x42 followed directly by a control write of 0x52. Writes to other registers between the two key bytes do not break the sequence. Any other byte returns the sequence to its start, and that includes a second 0x42. The 0x52 write does not itself set the enable. Once open, the key stays open until reset.
- R3: Bit 0 of a control write made while open is the enable. Setting it starts nothing by itself. At each later frame_start, in the following cycle, dl_load is high for one cycle, dl_pc equals the primary address and dl_run is 1. A frame_start in the same cycle as the enabling write is not acted on.
- R4: A control write made while open with bit 0 clear drives dl_run to 0 in the next cycle with no load pulse. It overrides a frame_start or end_of_list in the same cycle.
- R5: While the enable is set, every frame_start reloads the primary address, even when the list is already running.
- R6: A write of any value to register 3 produces, in the next cycle, a load pulse with the primary address and dl_run set to 1, whatever the enable.
- R7: A write to register 6 produces, in the next cycle, a load pulse with the secondary address and dl_run set to 1. If bit 3 of the written value is 1, dl_bank takes bits 2:0 of that value; otherwise dl_bank is unchanged.
- R8: end_of_list while running a list launched through register 6 loads the primary address and keeps dl_run at 1, with dl_bank unchanged. end_of_list while running any other list clears dl_run. end_of_list while not running has no effect.
- R9: A read request returns data in the next cycle. The map is: register 0 reads {unlocked, 0, enable bit 0}; registers 1 and 2 read the primary address low and high bytes; registers 4 and 5 read the secondary address low and high bytes; register 3 reads {5-bit VERSION in bits 7:3, vid_cfg in bits 2:0}; register 6 reads the bank, zero-extended; register 7 reads 0.
- R10: Launches are ordered by priority: a strobe write first, then frame_start while enabled, then end_of_list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 3 | Register index for the read |
| rd_data | output | 8 | Read byte, one cycle after rd_en |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| end_of_list | input | 1 | Executor reached the end of the current list |
| vid_cfg | input | 3 | Video-chip configuration code shown in register 3 reads |
| dl_run | output | 1 | Display list is executing |
| dl_load | output | 1 | One-cycle program-counter load pulse |
| dl_pc | output | 16 | Address to load into the program counter |
| dl_bank | output | 3 | Memory bank used for list fetches |

## Verification
The properties assume that at most one register write arrives per cycle and that frame_start and end_of_list are single-cycle pulses timed on the clock. The frame-start property is only required to hold in cycles with no register write, because a disabling control write takes priority over the frame. The stimulus drives every input just after the falling edge and never issues two writes at once. Where it combines a strobe or a control write with frame_start or end_of_list, it does so on purpose, to exercise the ordering in R4 and R10.

// File: rtl/dl_launch_pkg.sv
package dl_launch_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] REG_PLO  = 3'd1;
  localparam logic [REG_AW-1:0] REG_PHI  = 3'd2;
  localparam logic [REG_AW-1:0] REG_PGO  = 3'd3;
  localparam logic [REG_AW-1:0] REG_SLO  = 3'd4;
  localparam logic [REG_AW-1:0] REG_SHI  = 3'd5;
  localparam logic [REG_AW-1:0] REG_SGO  = 3'd6;

  localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h42;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'h52;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_OPEN  = 2'd2
  } unlock_t;
endpackage

// File: rtl/dl_unlock.sv
module dl_unlock
  import dl_launch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              open_o
);
  unlock_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= UL_IDLE;
    end else if (ctrl_wr) begin
      case (state)
        UL_IDLE: state <= (wr_data == KEY_FIRST)  ? UL_HALF : UL_IDLE;
        UL_HALF: state <= (wr_data == KEY_SECOND) ? UL_OPEN : UL_IDLE;
        default: state <= UL_OPEN;
      endcase
    end
  end

  assign open_o = (state == UL_OPEN);
endmodule

// File: rtl/dl_regs.sv
module dl_regs
  import dl_launch_pkg::*;
#(
  parameter int              BANK_W  = 3,
  parameter int              CFG_W   = 3,
  parameter logic [BYTE_W-CFG_W-1:0] VERSION = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [REG_AW-1:0]   rd_addr,
  input  logic                unlocked,
  input  logic                enable,
  input  logic [BANK_W-1:0]   bank,
  input  logic [CFG_W-1:0]    vid_cfg,
  output logic [2*BYTE_W-1:0] pri_addr,
  output logic [2*BYTE_W-1:0] sec_addr,
  output logic [BYTE_W-1:0]   rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pri_addr <= '0;
      sec_addr <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_PLO: pri_addr[BYTE_W-1:0]        <= wr_data;
        REG_PHI: pri_addr[2*BYTE_W-1:BYTE_W] <= wr_data;
        REG_SLO: sec_addr[BYTE_W-1:0]        <= wr_data;
        REG_SHI: sec_addr[2*BYTE_W-1:BYTE_W] <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        REG_CTRL: rd_data <= {unlocked, {(BYTE_W-2){1'b0}}, enable};
        REG_PLO:  rd_data <= pri_addr[BYTE_W-1:0];
        REG_PHI:  rd_data <= pri_addr[2*BYTE_W-1:BYTE_W];
        REG_PGO:  rd_data <= {VERSION, vid_cfg};
        REG_SLO:  rd_data <= sec_addr[BYTE_W-1:0];
        REG_SHI:  rd_data <= sec_addr[2*BYTE_W-1:BYTE_W];
        REG_SGO:  rd_data <= {{(BYTE_W-BANK_W){1'b0}}, bank};
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dl_sequencer.sv
module dl_sequencer
  import dl_launch_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctrl_wr_ok,
  input  logic                pgo_wr,
  input  logic                sgo_wr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                frame_start,
  input  logic                end_of_list,
  input  logic [2*BYTE_W-1:0] pri_addr,
  input  logic [2*BYTE_W-1:0] sec_addr,
  output logic                enable,
  output logic                run,
  output logic                load,
  output logic [2*BYTE_W-1:0] pc,
  output logic [BANK_W-1:0]   bank
);
  localparam int BANK_SEL_BIT = 3;

  logic in_sec;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      run    <= 1'b0;
      load   <= 1'b0;
      pc     <= '0;
      bank   <= '0;
      in_sec <= 1'b0;
    end else begin
      load <= 1'b0;
      if (ctrl_wr_ok) enable <= wr_data[0];
      if (ctrl_wr_ok && !wr_data[0]) begin
        run    <= 1'b0;
        in_sec <= 1'b0;
      end else if (pgo_wr) begin
        load   <= 1'b1;
        pc     <= pri_addr;
        run    <= 1'b1;
        in_sec <= 1'b0;
      end else if (sgo_wr) begin
        load   <= 1'b1;
        pc     <= sec_addr;
        run    <= 1'b1;
        in_sec <= 1'b1;
        if (wr_data[BANK_SEL_BIT]) bank <= wr_data[BANK_W-1:0];
      end else if (frame_start && enable) begin
        load   <= 1'b1;
        pc     <= pri_addr;
        run    <= 1'b1;
        in_sec <= 1'b0;
      end else if (end_of_list && run) begin
        if (in_sec) begin
          load   <= 1'b1;
          pc     <= pri_addr;
          in_sec <= 1'b0;
        end else begin
          run <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dl_launch_ctrl.sv
module dl_launch_ctrl
  import dl_launch_pkg::*;
#(
  parameter int                      BANK_W  = 3,
  parameter int                      CFG_W   = 3,
  parameter logic [BYTE_W-CFG_W-1:0] VERSION = 5'h03
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [REG_AW-1:0]   rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic                frame_start,
  input  logic                end_of_list,
  input  logic [CFG_W-1:0]    vid_cfg,
  output logic                dl_run,
  output logic                dl_load,
  output logic [2*BYTE_W-1:0] dl_pc,
  output logic [BANK_W-1:0]   dl_bank
);
  logic                ctrl_wr, unlocked, enable;
  logic [2*BYTE_W-1:0] pri_addr, sec_addr;

  assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);

  dl_unlock u_unlock (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wr_data(wr_data), .open_o(unlocked)
  );

  dl_regs #(.BANK_W(BANK_W), .CFG_W(CFG_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .unlocked(unlocked), .enable(enable),
    .bank(dl_bank), .vid_cfg(vid_cfg), .pri_addr(pri_addr), .sec_addr(sec_addr),
    .rd_data(rd_data)
  );

  dl_sequencer #(.BANK_W(BANK_W)) u_seq (
    .clk(clk), .rst(rst),
    .ctrl_wr_ok(ctrl_wr && unlocked),
    .pgo_wr(wr_en && (wr_addr == REG_PGO)),
    .sgo_wr(wr_en && (wr_addr == REG_SGO)),
    .wr_data(wr_data), .frame_start(frame_start), .end_of_list(end_of_list),
    .pri_addr(pri_addr), .sec_addr(sec_addr), .enable(enable),
    .run(dl_run), .load(dl_load), .pc(dl_pc), .bank(dl_bank)
  );
endmodule

// File: rtl/dl_launch_chk.sv
module dl_launch_chk
  import dl_launch_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [REG_AW-1:0]   wr_addr,
  input logic [BYTE_W-1:0]   wr_data,
  input logic                frame_start,
  input logic                unlocked,
  input logic                enable,
  input logic [2*BYTE_W-1:0] pri_addr,
  input logic [2*BYTE_W-1:0] sec_addr,
  input logic                dl_run,
  input logic                dl_load,
  input logic [2*BYTE_W-1:0] dl_pc,
  input logic [BANK_W-1:0]   dl_bank
);
  // R2
  locked_ctrl_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && wr_en && wr_addr == REG_CTRL) |=> $stable(enable));

  // R4
  stop_at_once_chk: assert property (@(posedge clk) disable iff (rst)
    (unlocked && wr_en && wr_addr == REG_CTRL && !wr_data[0]) |=> (!dl_run && !dl_load));

  // R6
  primary_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_PGO) |=> (dl_load && dl_run && dl_pc == $past(pri_addr)));

  // R7
  secondary_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_SGO && wr_data[3])
      |=> (dl_load && dl_pc == $past(sec_addr) && dl_bank == $past(wr_data[BANK_W-1:0])));

  // R3
  frame_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && enable && !wr_en) |=> (dl_load && dl_pc == $past(pri_addr)));

  // R3
  load_means_run_chk: assert property (@(posedge clk) disable iff (rst)
    dl_load |-> dl_run);
endmodule

bind dl_launch_ctrl dl_launch_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .frame_start(frame_start), .unlocked(unlocked), .enable(enable),
  .pri_addr(pri_addr), .sec_addr(sec_addr), .dl_run(dl_run), .dl_load(dl_load),
  .dl_pc(dl_pc), .dl_bank(dl_bank)
);

// File: tb/dl_launch_ctrl_test.sv
`timescale 1ns/1ps
module dl_launch_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, frame_start = 1'b0, end_of_list = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] vid_cfg = 3'b110;
  logic [7:0] rd_data;
  logic       dl_run, dl_load;
  logic [15:0] dl_pc;
  logic [2:0] dl_bank;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dl_launch_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .frame_start(frame_start),
    .end_of_list(end_of_list), .vid_cfg(vid_cfg), .dl_run(dl_run), .dl_load(dl_load),
    .dl_pc(dl_pc), .dl_bank(dl_bank)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int          m_key;
  bit          m_open, m_en, m_run, m_load, m_sec;
  logic [15:0] m_pc, m_pri, m_alt;
  logic [2:0]  m_bank;
  logic [7:0]  m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_key = 0; m_open = 0; m_en = 0; m_run = 0; m_load = 0; m_sec = 0;
      m_pc = 0; m_pri = 0; m_alt = 0; m_bank = 0; m_rd = 0;
    end else begin
      bit was_en;
      bit ctl_ok;
      was_en = m_en;
      ctl_ok = wr_en && wr_addr == 0 && m_open;
      m_load = 0;
      if (rd_en) begin
        case (rd_addr)
          3'd0: m_rd = {m_open, 6'd0, m_en};
          3'd1: m_rd = m_pri[7:0];
          3'd2: m_rd = m_pri[15:8];
          3'd3: m_rd = {5'h03, vid_cfg};
          3'd4: m_rd = m_alt[7:0];
          3'd5: m_rd = m_alt[15:8];
          3'd6: m_rd = {5'd0, m_bank};
          default: m_rd = 0;
        endcase
      end
      if (ctl_ok) m_en = wr_data[0];
      if (ctl_ok && !wr_data[0]) begin
        m_run = 0; m_sec = 0;
      end else if (wr_en && wr_addr == 3) begin
        m_load = 1; m_pc = m_pri; m_run = 1; m_sec = 0;
      end else if (wr_en && wr_addr == 6) begin
        m_load = 1; m_pc = m_alt; m_run = 1; m_sec = 1;
        if (wr_data[3]) m_bank = wr_data[2:0];
      end else if (frame_start && was_en) begin
        m_load = 1; m_pc = m_pri; m_run = 1; m_sec = 0;
      end else if (end_of_list && m_run) begin
        if (m_sec) begin m_load = 1; m_pc = m_pri; m_sec = 0; end
        else m_run = 0;
      end
      if (wr_en && wr_addr == 0 && !m_open) begin
        if (m_key == 0) m_key = (wr_data == 8'h42) ? 1 : 0;
        else begin
          m_open = (wr_data == 8'h52);
          m_key = 0;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd1: m_pri[7:0]  = wr_data;
          3'd2: m_pri[15:8] = wr_data;
          3'd4: m_alt[7:0]  = wr_data;
          3'd5: m_alt[15:8] = wr_data;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      chk("model run R3", dl_run, m_run);
      chk("model load R6", dl_load, m_load);
      chk("model pc R7", dl_pc, m_pc);
      chk("model bank R7", dl_bank, m_bank);
      chk("model rd R9", rd_data, m_rd);
    end
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic frame();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic eol();
    end_of_list = 1;
    @(negedge clk);
    end_of_list = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 run", dl_run, 0);
    chk("R1 load", dl_load, 0);
    chk("R1 bank", dl_bank, 0);
    rd(0); chk("R1 ctrl", rd_data, 8'h00);

    // R2: locked writes and broken key sequences
    wr(0, 8'h01); frame(); chk("R2 locked enable", dl_load, 0);
    wr(0, 8'h42); wr(0, 8'h41); wr(0, 8'h52); rd(0); chk("R2 wrong byte", rd_data, 8'h00);
    wr(0, 8'h42); wr(0, 8'h42); wr(0, 8'h52); rd(0); chk("R2 double key", rd_data, 8'h00);
    wr(0, 8'h42); wr(1, 8'h34); wr(0, 8'h52); rd(0); chk("R2 open", rd_data, 8'h80);
    wr(2, 8'h12); wr(4, 8'hCD); wr(5, 8'hAB);
    rd(1); chk("R9 pri lo", rd_data, 8'h34);
    rd(5); chk("R9 sec hi", rd_data, 8'hAB);

    // R3 / R5: frame launches
    frame(); chk("R3 disabled frame", dl_load, 0);
    wr(0, 8'h01); chk("R3 enable waits", dl_load, 0);
    frame(); chk("R3 load", dl_load, 1); chk("R3 pc", dl_pc, 16'h1234); chk("R3 run", dl_run, 1);
    @(negedge clk); chk("R3 pulse one cycle", dl_load, 0); chk("R3 still run", dl_run, 1);
    frame(); chk("R5 reload", dl_load, 1); chk("R5 pc", dl_pc, 16'h1234);

    // R8: end of a primary list, then end while idle
    eol(); chk("R8 primary end", dl_run, 0); chk("R8 no load", dl_load, 0);
    eol(); chk("R8 idle end", dl_run, 0);

    // R7 / R8: secondary launches and fall-back
    wr(6, 8'h0D); chk("R7 load", dl_load, 1); chk("R7 pc", dl_pc, 16'hABCD); chk("R7 bank", dl_bank, 3'd5);
    eol(); chk("R8 fallback load", dl_load, 1); chk("R8 fallback pc", dl_pc, 16'h1234);
    chk("R8 fallback run", dl_run, 1); chk("R8 bank kept", dl_bank, 3'd5);
    wr(6, 8'h05); chk("R7 no bank change", dl_bank, 3'd5); chk("R7 pc again", dl_pc, 16'hABCD);
    wr(6, 8'h0A); chk("R7 bank two", dl_bank, 3'd2);

    // R10: priorities
    frame_start = 1; wr(6, 8'h00); frame_start = 0;
    chk("R10 strobe over frame", dl_pc, 16'hABCD);
    frame();
    end_of_list = 1; frame(); end_of_list = 0;
    chk("R10 frame over end", dl_run, 1); chk("R10 frame load", dl_load, 1);

    // R4: immediate stop
    frame_start = 1; wr(0, 8'h00); frame_start = 0;
    chk("R4 stop run", dl_run, 0); chk("R4 stop load", dl_load, 0);
    frame(); chk("R4 stays stopped", dl_load, 0);

    // R6: primary strobe without enable
    wr(3, 8'h77); chk("R6 load", dl_load, 1); chk("R6 pc", dl_pc, 16'h1234); chk("R6 run", dl_run, 1);
    rd(3); chk("R9 version", rd_data, 8'h1E);
    rd(6); chk("R9 bank", rd_data, 8'h02);
    rd(7); chk("R9 empty", rd_data, 8'h00);
    wr(0, 8'h00); chk("R4 stop strobe list", dl_run, 0);

    // R3: frame in the same cycle as the enabling write
    frame_start = 1; wr(0, 8'h01); frame_start = 0;
    chk("R3 same cycle frame", dl_load, 0);
    frame(); chk("R3 later frame", dl_load, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule